// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit up-counting timer that makes a periodic rectangular pulse on a single output. The counter advances on a count-clock enable taken from an internal prescaler, whose division ratio is picked by a two-bit select. When the counter equals the period compare value, it returns to zero on the next count clock. This gives a repeating frame of (period + 1) count clocks.

The output is a flip-flop that inverts on a period match, on a duty match, or on both. Each match source has its own enable. Software writes a start level into the flip-flop through a load strobe with a two-bit command. With the flip-flop loaded high and both inversions enabled, the output is high for (duty + 1) count clocks in every frame. Software keeps duty below period for a sensible waveform. A separate output enable passes the flip-flop to the pin or holds the pin low. A sticky flag records a counter wrap from the all-ones value to zero. A one-shot trigger input exists but has no effect in this mode.

Top module: `ppg_timer`

## Requirements
- R1: While `run_i` is 0, the counter and the prescaler are held at zero, so counting restarts from zero when `run_i` rises.
- R2: `clk_sel_i` selects the count clock: 00 gives every system clock, 01 every 4th, 10 every 16th and 11 every 256th. The first count clock comes N system clocks after `run_i` rises, where N is the selected division.
- R3: On each count clock the counter increments. If the counter equals `period_i`, it clears to zero instead, so a frame lasts (period + 1) count clocks.
- R4: With `inv_period_i` set, the output flip-flop inverts on each count clock at which the counter equals `period_i`.
- R5: With `inv_duty_i` set, the output flip-flop inverts on each count clock at which the counter equals `duty_i`.
- R6: A cycle with `lvl_wr_i` high applies `lvl_cmd_i` to the flip-flop: 01 loads 0, 10 loads 1, 00 keeps the value, and 11 is ignored. A load takes precedence over inversions in the same cycle.
- R7: `pulse_o` follows the flip-flop while `out_en_i` is 1 and is 0 while it is 0.
- R8: With the flip-flop loaded to 1, both inversions enabled and duty < period, `pulse_o` is high for exactly (duty + 1) count clocks of every (period + 1).
- R9: `ovf_o` sets on the count clock at which the counter goes from 0xFFFF to 0. It stays set until a cycle with `ovf_clr_i` high and no new wrap.
- R10: `oneshot_trig_i` has no effect on the counter, the flip-flop or the output.
- R11: A clear caused by a period match below 0xFFFF does not set `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 counts, 0 stops and holds at zero |
| clk_sel_i | input | 2 | Count-clock division select |
| period_i | input | 16 | Period compare value |
| duty_i | input | 16 | Duty compare value |
| inv_period_i | input | 1 | Invert output on period match |
| inv_duty_i | input | 1 | Invert output on duty match |
| lvl_wr_i | input | 1 | Strobe applying the level command |
| lvl_cmd_i | input | 2 | Level command: 01 low, 10 high, 00/11 none |
| out_en_i | input | 1 | Output enable |
| oneshot_trig_i | input | 1 | One-shot trigger, inert in this mode |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cnt_o | output | 16 | Current counter value |
| pulse_o | output | 1 | Pulse output |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block at its default parameters: a 16-bit counter and a prescaler with shifts of 2, 4 and 8. With these values all four division ratios can be swept over small periods in a few thousand cycles, and the full 65536-count wrap for the overflow flag is still within reach. For each ratio and several period/duty pairs, the expected counter value and output level at every system clock are computed from the elapsed clock count by integer division and modulo. The number of duty and period matches so far fixes the flip-flop state.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [1:0] {
    LVL_KEEP = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } lvl_cmd_e;

  typedef enum logic [1:0] {
    SEL_D1   = 2'b00,
    SEL_D4   = 2'b01,
    SEL_D16  = 2'b10,
    SEL_D256 = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler
  import ppg_pkg::*;
#(
  parameter int SH1 = 2,
  parameter int SH2 = 4,
  parameter int SH3 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int PSC_W = SH3;
  localparam logic [PSC_W-1:0] M1 = PSC_W'((1 << SH1) - 1);
  localparam logic [PSC_W-1:0] M2 = PSC_W'((1 << SH2) - 1);
  localparam logic [PSC_W-1:0] M3 = PSC_W'((1 << SH3) - 1);

  logic [PSC_W-1:0] psc_q, mask;

  always_comb begin
    unique case (clk_sel_e'(sel_i))
      SEL_D1:   mask = '0;
      SEL_D4:   mask = M1;
      SEL_D16:  mask = M2;
      default:  mask = M3;
    endcase
  end

  assign tick_o = run_i && ((psc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (!run_i) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end

  p_stop_psc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> psc_q == '0);
  p_div1_every_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_i == 2'b00 && $past(run_i)) |-> tick_o);
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_period_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, wrap;

  assign at_period_o = (cnt_q == period_i);
  assign wrap        = tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= at_period_o ? '0 : cnt_q + 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_stop_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_o == '0);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_o == period_i) |=> cnt_o == '0);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_o != period_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_o));
  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_o == {CNT_W{1'b1}}) |=> ovf_o);
  p_ovf_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(tick_i && cnt_o == {CNT_W{1'b1}})) |=> !ovf_o);
endmodule

// File: rtl/ppg_out_ff.sv
module ppg_out_ff
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             at_period_i,
  input  logic             inv_period_i,
  input  logic             inv_duty_i,
  input  logic             lvl_wr_i,
  input  logic [1:0]       lvl_cmd_i,
  input  logic             out_en_i,
  output logic             ff_o,
  output logic             pulse_o
);
  logic ff_q, at_duty, hit_p, hit_d, flip;

  assign at_duty = (cnt_i == duty_i);
  assign hit_p   = inv_period_i && at_period_i;
  assign hit_d   = inv_duty_i && at_duty;
  assign flip    = tick_i && (hit_p ^ hit_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ff_q <= 1'b0;
    else if (lvl_wr_i && lvl_cmd_e'(lvl_cmd_i) == LVL_LOW)  ff_q <= 1'b0;
    else if (lvl_wr_i && lvl_cmd_e'(lvl_cmd_i) == LVL_HIGH) ff_q <= 1'b1;
    else if (flip)                                  ff_q <= ~ff_q;
  end

  assign ff_o    = ff_q;
  assign pulse_o = out_en_i & ff_q;

  p_load_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_wr_i && lvl_cmd_i == 2'b01) |=> !ff_o);
  p_load_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_wr_i && lvl_cmd_i == 2'b10) |=> ff_o);
  p_load_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_wr_i && lvl_cmd_i[1] == lvl_cmd_i[0] && !tick_i) |=> $stable(ff_o));
  p_inv_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && inv_period_i && at_period_i && !(inv_duty_i && cnt_i == duty_i) && !lvl_wr_i)
    |=> ff_o != $past(ff_o));
  p_inv_duty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && inv_duty_i && cnt_i == duty_i && !(inv_period_i && at_period_i) && !lvl_wr_i)
    |=> ff_o != $past(ff_o));
  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !lvl_wr_i) |=> $stable(ff_o));
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SH1   = 2,
  parameter int SH2   = 4,
  parameter int SH3   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       clk_sel_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             inv_period_i,
  input  logic             inv_duty_i,
  input  logic             lvl_wr_i,
  input  logic [1:0]       lvl_cmd_i,
  input  logic             out_en_i,
  input  logic             oneshot_trig_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pulse_o,
  output logic             ovf_o
);
  logic             cnt_tick, at_period, lvl_ff;
  logic [CNT_W-1:0] cnt;

  ppg_prescaler #(.SH1(SH1), .SH2(SH2), .SH3(SH3)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .sel_i  (clk_sel_i),
    .tick_o (cnt_tick)
  );

  ppg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .tick_i      (cnt_tick),
    .period_i    (period_i),
    .ovf_clr_i   (ovf_clr_i),
    .cnt_o       (cnt),
    .at_period_o (at_period),
    .ovf_o       (ovf_o)
  );

  ppg_out_ff #(.CNT_W(CNT_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (cnt_tick),
    .cnt_i        (cnt),
    .duty_i       (duty_i),
    .at_period_i  (at_period),
    .inv_period_i (inv_period_i),
    .inv_duty_i   (inv_duty_i),
    .lvl_wr_i     (lvl_wr_i),
    .lvl_cmd_i    (lvl_cmd_i),
    .out_en_i     (out_en_i),
    .ff_o         (lvl_ff),
    .pulse_o      (pulse_o)
  );

  assign cnt_o = cnt;

  // trigger is not routed anywhere in this mode
  p_oneshot_inert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oneshot_trig_i && !cnt_tick && !lvl_wr_i) |=> ($stable(lvl_ff) && (!run_i || $stable(cnt_o))));
endmodule

// File: tb/ppg_timer_tb_top.sv
module ppg_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [15:0] per = 16'd1, dut = 16'd0;
  logic        invp = 1'b0, invd = 1'b0, lwr = 1'b0, oen = 1'b0, trig = 1'b0, oclr = 1'b0;
  logic [1:0]  lcmd = 2'b00;
  logic [15:0] cnt;
  logic        pulse, ovf;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  ppg_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .clk_sel_i(sel),
    .period_i(per), .duty_i(dut), .inv_period_i(invp), .inv_duty_i(invd),
    .lvl_wr_i(lwr), .lvl_cmd_i(lcmd), .out_en_i(oen), .oneshot_trig_i(trig),
    .ovf_clr_i(oclr), .cnt_o(cnt), .pulse_o(pulse), .ovf_o(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic load_lvl(input logic [1:0] c);
    @(negedge clk);
    lwr = 1'b1; lcmd = c;
    @(posedge clk);
    @(negedge clk);
    lwr = 1'b0;
  endtask

  // stop, configure, load level, then run and compare each clock against arithmetic model
  task automatic run_cfg(input int s, input int p, input int d, input bit ip, input bit id,
                         input bit hi, input bit oe, input bit tg, input string tag);
    int n, k_max, hi_cnt;
    bit lvl;
    n = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 16 : 256;
    @(negedge clk);
    run = 1'b0; sel = 2'(s); per = 16'(p); dut = 16'(d);
    invp = ip; invd = id; oen = oe;
    lwr = 1'b1; lcmd = hi ? 2'b10 : 2'b01;
    lvl = hi;
    @(posedge clk);
    @(negedge clk);
    lwr = 1'b0;
    chk("R1 stopped cnt", int'(cnt), 0);
    run = 1'b1;
    k_max = 2 * (p + 1) * n + 3;
    hi_cnt = 0;
    for (int k = 1; k <= k_max; k++) begin
      int t, c, nd, np;
      bit ff;
      @(posedge clk);
      @(negedge clk);
      trig = tg & k[1];
      t  = k / n;
      c  = t % (p + 1);
      nd = (t > d) ? (t - 1 - d) / (p + 1) + 1 : 0;
      np = (t > p) ? (t - 1 - p) / (p + 1) + 1 : 0;
      ff = lvl ^ (id & nd[0]) ^ (ip & np[0]);
      chk({tag, " R2 R3 cnt"}, int'(cnt), c);
      chk({tag, " R4 R5 R7 R10 pulse"}, int'(pulse), int'(oe & ff));
      if (k >= n * (p + 1) && k < 2 * n * (p + 1)) hi_cnt += int'(pulse);
    end
    trig = 1'b0;
    if (ip && id && hi && oe)
      chk({tag, " R8 high clocks per frame"}, hi_cnt, n * (d + 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset cnt", int'(cnt), 0);
    chk("reset pulse", int'(pulse), 0);
    chk("reset ovf", int'(ovf), 0);
    rst_n = 1'b1;

    // R6 level commands while stopped, output enabled
    @(negedge clk); oen = 1'b1;
    load_lvl(2'b10); chk("R6 load high", int'(pulse), 1);
    load_lvl(2'b11); chk("R6 11 ignored (high)", int'(pulse), 1);
    load_lvl(2'b00); chk("R6 00 keeps (high)", int'(pulse), 1);
    load_lvl(2'b01); chk("R6 load low", int'(pulse), 0);
    load_lvl(2'b11); chk("R6 11 ignored (low)", int'(pulse), 0);
    load_lvl(2'b00); chk("R6 00 keeps (low)", int'(pulse), 0);
    load_lvl(2'b10);
    @(negedge clk); oen = 1'b0;
    @(negedge clk); chk("R7 disabled output low", int'(pulse), 0);

    // main sweep: all divisions, several period/duty pairs
    for (int s = 0; s < 4; s++) begin
      run_cfg(s, 1, 0, 1, 1, 1, 1, 1, "sweep");
      run_cfg(s, 3, 1, 1, 1, 1, 1, 0, "sweep");
      run_cfg(s, 5, 0, 1, 1, 1, 1, 1, "sweep");
      run_cfg(s, 4, 3, 1, 1, 1, 1, 0, "sweep");
      run_cfg(s, 6, 2, 1, 1, 1, 1, 1, "sweep");
    end
    // inversion source variants, low start, disabled output
    run_cfg(0, 5, 2, 1, 0, 0, 1, 1, "period-only");
    run_cfg(1, 5, 2, 0, 1, 0, 1, 1, "duty-only");
    run_cfg(0, 4, 1, 0, 0, 1, 1, 1, "no-inv");
    run_cfg(0, 4, 1, 1, 1, 0, 1, 0, "low-start");
    run_cfg(1, 3, 0, 1, 1, 1, 0, 1, "oe-off");
    chk("R11 no overflow on period clears", int'(ovf), 0);

    // R9 full wrap
    @(negedge clk);
    run = 1'b0; sel = 2'b00; per = 16'hFFFF; dut = 16'd0; invp = 1'b0; invd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    run = 1'b1;
    repeat (65535) @(posedge clk);
    @(negedge clk);
    chk("R9 cnt at max", int'(cnt), 65535);
    chk("R9 no flag before wrap", int'(ovf), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 cnt wrapped", int'(cnt), 0);
    chk("R9 flag set", int'(ovf), 1);
    trig = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    chk("R9 flag sticky", int'(ovf), 1);
    oclr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    oclr = 1'b0;
    chk("R9 flag cleared", int'(ovf), 0);
    run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 stop clears cnt", int'(cnt), 0);

    finish_run();
  end
endmodule